// File: doc/BRIEF.md
# I-Structure Memory with Deferred Reads

This block is a word-addressed memory for a dataflow machine. Each request names a cell, an operation, a data word, a compare word and a return tag. Any result goes back on a single response port, labelled with the tag of the request that asked for it. The address space has two parts, split at a tier boundary. Cells below the boundary are plain storage. Cells at or above it carry a two-bit presence state and follow write-once, read-many rules.

A read of a presence-tracked cell that has no value yet is not an error and does not stall. The block records it in a small shared table of pending reads, holding the cell address and the return tag. When the producing write arrives, the block answers every pending read for that cell automatically, one response per cycle. Read-and-increment, read-and-decrement and compare-and-swap give atomic updates. A page register offers plain storage. Every change of presence state is reported on a dedicated output as an old-state/new-state pair.

Top module: `isr_mem`

## Requirements
- R1: After reset, every cell is empty, `req_ready` is high and no response, error or presence event is signalled.
- R2: For addresses below the tier boundary (256), the cell is plain storage. Writes always overwrite the cell without error. Reads answer at once. No presence event is ever produced there.
- R3: Presence codes are 00 empty, 01 waiting and 10 full. A write (op 1) to an empty tracked cell stores the data and reports 00->10. A read (op 0) of a full cell answers in the next cycle with the stored data and the request's tag.
- R4: A read of an empty or waiting tracked cell produces no response and is stored in the pending table. Only the first such read reports 00->01.
- R5: A write to a waiting cell stores the data and reports 01->10. It then sends one response per pending read of that cell, each carrying the written data and that read's tag. Responses go one per cycle, lowest table entry first, and `req_ready` stays low until all are sent.
- R6: A write to a full tracked cell raises `err_flag` for one cycle, leaves the stored value unchanged and reports no presence event.
- R7: Clear (op 2) turns a full tracked cell to empty and reports 10->00, keeping the data word. It leaves an empty cell as it is, without error. On a waiting cell it raises `err_flag` and keeps the pending reads, which a later write still answers.
- R8: Read-and-increment (op 3) and read-and-decrement (op 4) return the old value and store the value plus or minus one, wrapping. They act on full tracked cells and on any plain cell. On a tracked cell that is not full they raise `err_flag` and change nothing.
- R9: Compare-and-swap (op 5) returns the old value. It stores `req_data` only when the old value equals `req_cmp`.
- R10: The pending table holds 8 entries. While it is full, a read that would need an entry keeps `req_ready` low. A read of a full cell is still accepted. Once entries are freed, the held read is accepted.
- R11: Raw read (op 6) returns the stored word at any address, regardless of presence and without deferring. Op codes 9 to 15 raise `err_flag` and have no other effect.
- R12: Set-page (op 7) loads `req_data` into the page register, which resets to 0, and responds with the previous page value. Write-immediate (op 8) stores into a plain cell without a response. On a tracked cell it raises `err_flag` and leaves the cell empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_op | input | 4 | Operation code |
| req_addr | input | 9 | Cell address |
| req_data | input | 16 | Write, new or page value |
| req_cmp | input | 16 | Compare value for compare-and-swap |
| req_tag | input | 8 | Return tag |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_tag | output | 8 | Tag of the request being answered |
| rsp_data | output | 16 | Response data |
| err_flag | output | 1 | One-cycle error pulse for the accepted request |
| pres_valid | output | 1 | Presence transition happened |
| pres_addr | output | 9 | Cell whose presence changed |
| pres_old | output | 2 | Presence before the change |
| pres_new | output | 2 | Presence after the change |

## Verification
The deferral path is tried with three read patterns:
- Reads spread over two cells, with two reads sharing one cell. This separates answering by address from answering everything, and shows that the second read of a waiting cell produces no extra transition.
- Eight reads of one cell. This fills the pending table and shows that backpressure applies only to reads that need an entry, since a read of a full cell passes meanwhile.
- Clear of a waiting cell followed by its write. This shows that pending reads survive the rejected clear.

Atomic operations are run on tracked and plain cells and on matching and non-matching compare values. Increment wraps at the top of the word. Write-once violations, illegal codes and write-immediate above the boundary are checked for the error pulse and for the absence of a state change.

// File: rtl/isr_pkg.sv
package isr_pkg;

  typedef enum logic [1:0] {
    PR_EMPTY = 2'b00,
    PR_WAIT  = 2'b01,
    PR_FULL  = 2'b10
  } pres_e;

  typedef enum logic [3:0] {
    OP_READ  = 4'd0,
    OP_WRITE = 4'd1,
    OP_CLEAR = 4'd2,
    OP_INC   = 4'd3,
    OP_DEC   = 4'd4,
    OP_CAS   = 4'd5,
    OP_RAW   = 4'd6,
    OP_PAGE  = 4'd7,
    OP_WIMM  = 4'd8
  } op_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_DRAIN = 1'b1
  } st_e;

endpackage

// File: rtl/isr_rst_sync.sv
module isr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/isr_cell_store.sv
module isr_cell_store #(
  parameter int CELLS = 512,
  parameter int DW    = 16,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  input  logic          pwe,
  input  logic [1:0]    pval,
  output logic [DW-1:0] rdata,
  output logic [1:0]    rpres
);
  logic [DW-1:0] mem  [CELLS];
  logic [1:0]    pres [CELLS];

  // data words carry no reset
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CELLS; i++) pres[i] <= 2'b00;
    end else if (pwe) begin
      pres[addr] <= pval;
    end
  end

  assign rdata = mem[addr];
  assign rpres = pres[addr];
endmodule

// File: rtl/isr_defer_tbl.sv
module isr_defer_tbl #(
  parameter int N  = 8,
  parameter int AW = 9,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_en,
  input  logic [AW-1:0] alloc_addr,
  input  logic [TW-1:0] alloc_tag,
  input  logic [AW-1:0] look_addr,
  input  logic          free_en,
  output logic          full,
  output logic          hit,
  output logic [TW-1:0] hit_tag
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]  v_q;
  logic [AW-1:0] a_q [N];
  logic [TW-1:0] t_q [N];
  logic [IW-1:0] free_idx;
  logic [IW-1:0] hit_idx;

  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!v_q[i]) free_idx = IW'(i);
    end
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v_q[i] && (a_q[i] == look_addr)) begin
        hit     = 1'b1;
        hit_idx = IW'(i);
      end
    end
  end

  assign full    = &v_q;
  assign hit_tag = t_q[hit_idx];

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic take, drop;
    assign take = alloc_en && (free_idx == IW'(g));
    assign drop = free_en && hit && (hit_idx == IW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    v_q[g] <= 1'b0;
      else if (take) v_q[g] <= 1'b1;
      else if (drop) v_q[g] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (take) begin
        a_q[g] <= alloc_addr;
        t_q[g] <= alloc_tag;
      end
    end
  end
endmodule

// File: rtl/isr_mem.sv
module isr_mem #(
  parameter int CELLS   = 512,
  parameter int TIER    = 256,
  parameter int DW      = 16,
  parameter int TW      = 8,
  parameter int DEFER_N = 8,
  localparam int AW     = $clog2(CELLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [3:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic [DW-1:0] req_cmp,
  input  logic [TW-1:0] req_tag,
  output logic          rsp_valid,
  output logic [TW-1:0] rsp_tag,
  output logic [DW-1:0] rsp_data,
  output logic          err_flag,
  output logic          pres_valid,
  output logic [AW-1:0] pres_addr,
  output logic [1:0]    pres_old,
  output logic [1:0]    pres_new
);
  import isr_pkg::*;

  logic          rst_sn;
  st_e           st, st_n;
  logic          acc, is_raw, tbl_full, alloc_en, free_en, hit;
  logic [TW-1:0] hit_tag;
  logic [DW-1:0] cell_d;
  logic [1:0]    cell_p;
  logic          mem_we, pw_en;
  logic [DW-1:0] mem_wd;
  logic [1:0]    pw_val;
  logic          rsp_v_n, err_n, pv_n, drain_ld, page_en;
  logic [TW-1:0] rsp_tag_n;
  logic [DW-1:0] rsp_data_n;
  logic [AW-1:0] drain_addr;
  logic [DW-1:0] drain_data, page;

  isr_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  isr_cell_store #(.CELLS(CELLS), .DW(DW), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_sn), .addr(req_addr), .we(mem_we), .wdata(mem_wd),
    .pwe(pw_en), .pval(pw_val), .rdata(cell_d), .rpres(cell_p)
  );

  isr_defer_tbl #(.N(DEFER_N), .AW(AW), .TW(TW)) u_tbl (
    .clk(clk), .rst_n(rst_sn), .alloc_en(alloc_en), .alloc_addr(req_addr),
    .alloc_tag(req_tag), .look_addr(drain_addr), .free_en(free_en),
    .full(tbl_full), .hit(hit), .hit_tag(hit_tag)
  );

  assign is_raw    = (req_addr < AW'(TIER));
  assign req_ready = (st == ST_IDLE) &&
                     !((req_op == OP_READ) && !is_raw && (cell_p != PR_FULL) && tbl_full);
  assign acc       = req_valid && req_ready;

  // next-state logic
  always_comb begin
    st_n       = st;
    rsp_v_n    = 1'b0;
    rsp_tag_n  = req_tag;
    rsp_data_n = cell_d;
    err_n      = 1'b0;
    pv_n       = 1'b0;
    mem_we     = 1'b0;
    mem_wd     = req_data;
    pw_en      = 1'b0;
    pw_val     = cell_p;
    alloc_en   = 1'b0;
    free_en    = 1'b0;
    drain_ld   = 1'b0;
    page_en    = 1'b0;
    if (st == ST_DRAIN) begin
      if (hit) begin
        rsp_v_n    = 1'b1;
        rsp_tag_n  = hit_tag;
        rsp_data_n = drain_data;
        free_en    = 1'b1;
      end else begin
        st_n = ST_IDLE;
      end
    end else if (acc) begin
      case (req_op)
        OP_READ: begin
          if (is_raw || cell_p == PR_FULL) begin
            rsp_v_n = 1'b1;
          end else begin
            alloc_en = 1'b1;
            if (cell_p == PR_EMPTY) begin
              pw_en  = 1'b1;
              pw_val = PR_WAIT;
              pv_n   = 1'b1;
            end
          end
        end
        OP_WRITE: begin
          if (is_raw) begin
            mem_we = 1'b1;
          end else if (cell_p == PR_FULL) begin
            err_n = 1'b1;
          end else begin
            mem_we = 1'b1;
            pw_en  = 1'b1;
            pw_val = PR_FULL;
            pv_n   = 1'b1;
            if (cell_p == PR_WAIT) begin
              st_n     = ST_DRAIN;
              drain_ld = 1'b1;
            end
          end
        end
        OP_CLEAR: begin
          if (!is_raw) begin
            if (cell_p == PR_FULL) begin
              pw_en  = 1'b1;
              pw_val = PR_EMPTY;
              pv_n   = 1'b1;
            end else if (cell_p == PR_WAIT) begin
              err_n = 1'b1;
            end
          end
        end
        OP_INC, OP_DEC, OP_CAS: begin
          if (is_raw || cell_p == PR_FULL) begin
            rsp_v_n = 1'b1;
            if (req_op == OP_INC) begin
              mem_we = 1'b1;
              mem_wd = cell_d + DW'(1);
            end else if (req_op == OP_DEC) begin
              mem_we = 1'b1;
              mem_wd = cell_d - DW'(1);
            end else begin
              mem_we = (cell_d == req_cmp);
            end
          end else begin
            err_n = 1'b1;
          end
        end
        OP_RAW: rsp_v_n = 1'b1;
        OP_PAGE: begin
          rsp_v_n    = 1'b1;
          rsp_data_n = page;
          page_en    = 1'b1;
        end
        OP_WIMM: begin
          if (is_raw) mem_we = 1'b1;
          else        err_n  = 1'b1;
        end
        default: err_n = 1'b1;
      endcase
    end
  end

  // registers with reset
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st         <= ST_IDLE;
      rsp_valid  <= 1'b0;
      err_flag   <= 1'b0;
      pres_valid <= 1'b0;
      page       <= '0;
    end else begin
      st         <= st_n;
      rsp_valid  <= rsp_v_n;
      err_flag   <= err_n;
      pres_valid <= pv_n;
      if (page_en) page <= req_data;
    end
  end

  // payload registers, enabled only
  always_ff @(posedge clk) begin
    if (rsp_v_n) begin
      rsp_tag  <= rsp_tag_n;
      rsp_data <= rsp_data_n;
    end
    if (pv_n) begin
      pres_addr <= req_addr;
      pres_old  <= cell_p;
      pres_new  <= pw_val;
    end
    if (drain_ld) begin
      drain_addr <= req_addr;
      drain_data <= req_data;
    end
  end
endmodule

// File: rtl/isr_chk.sv
module isr_chk #(
  parameter int DW = 16,
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc,
  input logic [3:0]    req_op,
  input logic          is_raw,
  input logic [1:0]    cell_p,
  input logic          tbl_full,
  input logic          alloc_en,
  input logic [DW-1:0] req_data,
  input logic [TW-1:0] req_tag,
  input logic          rsp_valid,
  input logic [TW-1:0] rsp_tag,
  input logic [DW-1:0] rsp_data,
  input logic          err_flag,
  input logic          pres_valid,
  input logic [1:0]    pres_old,
  input logic [1:0]    pres_new
);
  import isr_pkg::*;

  AST_NO_ALLOC_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_full |-> !alloc_en); // R10

  AST_PRES_STEP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    pres_valid |-> (pres_old != pres_new) && !(pres_old == PR_FULL && pres_new == PR_WAIT)); // R4

  AST_READ_FULL_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_op == OP_READ && !is_raw && cell_p == PR_FULL
    |=> rsp_valid && rsp_tag == $past(req_tag)); // R3

  AST_DOUBLE_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_op == OP_WRITE && !is_raw && cell_p == PR_FULL
    |=> err_flag && !pres_valid); // R6

  AST_WAIT_WRITE_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_op == OP_WRITE && !is_raw && cell_p == PR_WAIT
    |=> ##1 rsp_valid && rsp_data == $past(req_data, 2)); // R5

  AST_RAW_NO_PRES: assert property (@(posedge clk) disable iff (!rst_n)
    acc && is_raw |=> !pres_valid); // R2
endmodule

bind isr_mem isr_chk #(.DW(DW), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_sn), .acc(acc), .req_op(req_op), .is_raw(is_raw),
  .cell_p(cell_p), .tbl_full(tbl_full), .alloc_en(alloc_en), .req_data(req_data),
  .req_tag(req_tag), .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
  .err_flag(err_flag), .pres_valid(pres_valid), .pres_old(pres_old), .pres_new(pres_new)
);

// File: tb/sim_isr_mem.sv
module sim_isr_mem;
  logic        clk, rst_n;
  logic        req_valid, req_ready;
  logic [3:0]  req_op;
  logic [8:0]  req_addr;
  logic [15:0] req_data, req_cmp;
  logic [7:0]  req_tag;
  logic        rsp_valid;
  logic [7:0]  rsp_tag;
  logic [15:0] rsp_data;
  logic        err_flag, pres_valid;
  logic [8:0]  pres_addr;
  logic [1:0]  pres_old, pres_new;

  typedef struct {
    logic [7:0]  tag;
    logic [15:0] data;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  exp_t item;
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;

  isr_mem u0 (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic expect_rsp(int tag, int data, string r);
    exp_t e;
    e.tag  = 8'(tag);
    e.data = 16'(data);
    e.req  = r;
    exp_q.push_back(e);
  endtask

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic send(int op, int addr, int data, int cmp, int tag);
    req_valid = 1'b1;
    req_op    = 4'(op);
    req_addr  = 9'(addr);
    req_data  = 16'(data);
    req_cmp   = 16'(cmp);
    req_tag   = 8'(tag);
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic chk_pres(string r, bit v, int o, int n);
    chk({r, " pres_valid"}, 32'(pres_valid), 32'(v));
    if (v) begin
      chk({r, " pres_old"}, 32'(pres_old), 32'(o));
      chk({r, " pres_new"}, 32'(pres_new), 32'(n));
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R4 unexpected response tag=%0h data=%0h expected=none", rsp_tag, rsp_data);
      end else begin
        item = exp_q.pop_front();
        chk({item.req, " rsp_tag"}, 32'(rsp_tag), 32'(item.tag));
        chk({item.req, " rsp_data"}, 32'(rsp_data), 32'(item.data));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = 4'd0; req_addr = 9'd300;
    req_data = '0; req_cmp = '0; req_tag = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 ready", 32'(req_ready), 1);
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    chk("R1 err", 32'(err_flag), 0);
    chk("R1 pres_valid", 32'(pres_valid), 0);

    // R2 plain tier
    send(1, 10, 'h1111, 0, 0);
    chk_pres("R2", 0, 0, 0);
    send(1, 10, 'h2222, 0, 0);
    chk("R2 rewrite err", 32'(err_flag), 0);
    expect_rsp(1, 'h2222, "R2");
    send(0, 10, 0, 0, 1);

    // R3 write then read
    send(1, 300, 'hABCD, 0, 0);
    chk_pres("R3", 1, 0, 2);
    chk("R3 pres_addr", 32'(pres_addr), 300);
    expect_rsp(2, 'hABCD, "R3");
    send(0, 300, 0, 0, 2);

    // R6 second write
    send(1, 300, 'h5555, 0, 0);
    chk("R6 err", 32'(err_flag), 1);
    chk_pres("R6", 0, 0, 0);
    expect_rsp(3, 'hABCD, "R6");
    send(0, 300, 0, 0, 3);

    // R4 / R5 deferred reads over two cells
    send(0, 400, 0, 0, 'h20);
    chk_pres("R4 first", 1, 0, 1);
    send(0, 401, 0, 0, 'h21);
    chk_pres("R4 other", 1, 0, 1);
    send(0, 400, 0, 0, 'h22);
    chk_pres("R4 second", 0, 0, 0);
    expect_rsp('h20, 'h0400, "R5");
    expect_rsp('h22, 'h0400, "R5");
    send(1, 400, 'h0400, 0, 0);
    chk_pres("R5", 1, 1, 2);
    #1;
    chk("R5 ready low while answering", 32'(req_ready), 0);
    expect_rsp('h21, 'h0401, "R5");
    send(1, 401, 'h0401, 0, 0);

    // R7 clear
    send(2, 300, 0, 0, 0);
    chk_pres("R7 clear full", 1, 2, 0);
    expect_rsp(4, 'hABCD, "R11");
    send(6, 300, 0, 0, 4);
    send(2, 501, 0, 0, 0);
    chk("R7 clear empty err", 32'(err_flag), 0);
    chk_pres("R7 clear empty", 0, 0, 0);
    send(0, 500, 0, 0, 'h30);
    send(2, 500, 0, 0, 0);
    chk("R7 clear waiting err", 32'(err_flag), 1);
    chk_pres("R7 clear waiting", 0, 0, 0);
    expect_rsp('h30, 'h0777, "R7");
    send(1, 500, 'h0777, 0, 0);
    chk_pres("R7 kept waiting", 1, 1, 2);

    // R8 increment / decrement
    send(1, 310, 'h00FF, 0, 0);
    expect_rsp(5, 'h00FF, "R8");
    send(3, 310, 0, 0, 5);
    expect_rsp(6, 'h0100, "R8");
    send(4, 310, 0, 0, 6);
    expect_rsp(7, 'h00FF, "R8");
    send(0, 310, 0, 0, 7);
    send(1, 20, 'hFFFF, 0, 0);
    expect_rsp(8, 'hFFFF, "R8");
    send(3, 20, 0, 0, 8);
    expect_rsp(9, 'h0000, "R8");
    send(0, 20, 0, 0, 9);
    send(3, 320, 0, 0, 'h50);
    chk("R8 inc empty err", 32'(err_flag), 1);
    chk_pres("R8 inc empty", 0, 0, 0);

    // R9 compare-and-swap
    send(1, 330, 'h1234, 0, 0);
    expect_rsp(10, 'h1234, "R9");
    send(5, 330, 'h4321, 'h9999, 10);
    expect_rsp(11, 'h1234, "R9");
    send(0, 330, 0, 0, 11);
    expect_rsp(12, 'h1234, "R9");
    send(5, 330, 'h4321, 'h1234, 12);
    expect_rsp(13, 'h4321, "R9");
    send(0, 330, 0, 0, 13);

    // R12 page register and write-immediate
    expect_rsp(14, 'h0000, "R12");
    send(7, 0, 'h0055, 0, 14);
    expect_rsp(15, 'h0055, "R12");
    send(7, 0, 'h00AA, 0, 15);
    send(8, 30, 'h7777, 0, 0);
    chk("R12 wimm plain err", 32'(err_flag), 0);
    expect_rsp(16, 'h7777, "R12");
    send(0, 30, 0, 0, 16);
    send(8, 340, 'h0001, 0, 0);
    chk("R12 wimm tracked err", 32'(err_flag), 1);
    send(1, 340, 'h0002, 0, 0);
    chk("R12 tracked cell still empty err", 32'(err_flag), 0);
    chk_pres("R12", 1, 0, 2);

    // R11 undefined code
    send(9, 10, 0, 0, 0);
    chk("R11 bad op err", 32'(err_flag), 1);

    // R10 table capacity
    for (int i = 0; i < 8; i++) send(0, 460, 0, 0, 'h40 + i);
    req_valid = 1'b1; req_op = 4'd0; req_addr = 9'd461; req_tag = 8'h49;
    #1;
    chk("R10 ready low when table full", 32'(req_ready), 0);
    @(negedge clk); #1;
    chk("R10 ready still low", 32'(req_ready), 0);
    req_valid = 1'b0;
    expect_rsp('h48, 'h00FF, "R10");
    send(0, 310, 0, 0, 'h48);
    for (int i = 0; i < 8; i++) expect_rsp('h40 + i, 'h0460, "R10");
    send(1, 460, 'h0460, 0, 0);
    send(0, 461, 0, 0, 'h49);
    chk_pres("R10 held read accepted", 1, 0, 1);
    expect_rsp('h49, 'h0461, "R10");
    send(1, 461, 'h0461, 0, 0);

    repeat (6) @(negedge clk);
    chk("R5 all expected responses seen", 32'(exp_q.size()), 0);
    report();
  end
endmodule